// File: doc/BRIEF.md
# Ethernet Payload Block Splitter and Recombiner

This block sits in front of a 128-bit block cipher on a frame path. A minimum-length Ethernet frame comes in one byte at a time. The block keeps the 22 header bytes (preamble, start delimiter, both addresses and the length field) and sends none of them to the cipher. It packs the 46 payload bytes into three 128-bit blocks and fills the two unused trailing bytes with zeros. The three blocks are offered to the cipher as one 384-bit word.

When the cipher returns its three processed blocks, the block reuses the same payload storage to hold them. It then sends out a 68-byte frame: the stored header unchanged, followed by the 46 processed payload bytes. The two pad positions are dropped. Only one frame is in flight at a time.

All four data interfaces use valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are high.
- Once valid is raised, it stays high, and the data and markers stay stable, until the transfer completes.
- Input ready is high only while the block is collecting a frame. It drops when the three blocks are waiting for the cipher, and it stays low until the last rebuilt byte has left.
- A frame whose end marker arrives too early is dropped. The block raises a one-cycle error pulse for it.

Top module: `eth_payload_splitter`

## Requirements
- R1: After reset, `in_ready` is 1 and `blk_valid`, `ret_ready`, `out_valid` and `err_short` are all 0.
- R2: Payload byte k (0 to 45) is placed at `blk_data[383-8k -: 8]`. Block 1 is bits 383:256, block 2 is bits 255:128 and block 3 is bits 127:0. Each block is filled from its most significant byte downward.
- R3: The two pad bytes `blk_data[15:0]` are always zero. This holds even when the previous returned word had nonzero bytes in those positions.
- R4: `blk_valid` rises in the cycle after the end-marked byte at frame index 67 or higher is accepted. It then stays high with stable `blk_data` until `blk_ready` is seen, and `in_ready` is 0 during that time.
- R5: If the end marker is accepted at frame index 66 or lower, `err_short` is 1 for exactly the next cycle. No `blk_valid` follows, and `in_ready` stays 1, so the next frame is taken normally.
- R6: Bytes that arrive while no frame is open, meaning no start marker has been seen since the last end marker, are ignored. A start marker in the middle of a frame restarts collection at index 0.
- R7: In a frame longer than 68 bytes, every byte past index 67 is discarded. The block waits for the end marker and then proceeds as for a 68-byte frame.
- R8: `ret_ready` is 1 only after the `blk_valid`/`blk_ready` transfer. A `ret_valid` pulse while it is high captures `ret_data`, using the same byte layout as R2.
- R9: The output is 68 bytes, with `out_sof` on byte 0 and `out_eof` on byte 67. Bytes 0 to 21 are the header bytes as received. Bytes 22 to 67 are returned payload bytes 0 to 45. The returned pad bytes are never emitted.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values.
- R11: `in_ready` returns to 1 in the cycle after byte 67 is transferred. It is 0 at all times while blocks, returned data or output bytes are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| blk_valid | output | 1 | Three payload blocks available |
| blk_ready | input | 1 | Cipher takes the blocks |
| blk_data | output | 384 | Three packed payload blocks, block 1 most significant |
| ret_valid | input | 1 | Processed blocks available |
| ret_ready | output | 1 | Block is waiting for processed blocks |
| ret_data | input | 384 | Three processed blocks, same layout as `blk_data` |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Rebuilt frame byte |
| out_sof | output | 1 | First byte of the rebuilt frame |
| out_eof | output | 1 | Last byte of the rebuilt frame |
| err_short | output | 1 | One-cycle pulse when a short frame is discarded |

## Verification
The hardest case to reach from the ports is the pad-zero guarantee across frames. It only matters after a returned word has put nonzero data in the pad positions and a later frame is then split. To reach it, every return drives nonzero pad bytes, and each following frame checks that the pad field of `blk_data` is zero. The short-frame path is swept over every end position from index 0 through 66. The bench also covers output stalls driven by a rotating back-pressure pattern, stray bytes sent before any start marker, a frame restarted in its middle, and an over-long frame.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_OFFER   = 2'd1,
    ST_AWAIT   = 2'd2,
    ST_EMIT    = 2'd3
  } eps_state_e;
endpackage

// File: rtl/eps_ingest.sv
module eps_ingest #(
  parameter int FRAME_BYTES = 68,
  parameter int IW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          done,
  output logic          err_short
);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BYTES - 1);
  localparam logic [IW-1:0] FULL = IW'(FRAME_BYTES);

  logic          open_q;
  logic [IW-1:0] cnt_q;
  logic          take;
  logic          short_c;

  // a byte counts only inside an open frame or when it opens one
  assign take    = en && in_valid && (in_sof || open_q);
  assign wr_idx  = in_sof ? '0 : cnt_q;
  assign wr_en   = take && (wr_idx < FULL);
  assign done    = take && in_eof && (wr_idx >= LAST);
  assign short_c = take && in_eof && (wr_idx < LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cnt_q     <= '0;
      err_short <= 1'b0;
    end else begin
      err_short <= short_c;
      if (take) begin
        open_q <= !in_eof;
        cnt_q  <= (wr_idx >= FULL) ? FULL : wr_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eps_store.sv
module eps_store #(
  parameter int HDR_BYTES = 22,
  parameter int PAY_BYTES = 46,
  parameter int SLOTS     = 48,
  parameter int IW        = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  input  logic               ld_en,
  input  logic [SLOTS*8-1:0] ld_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_byte,
  output logic [SLOTS*8-1:0] blk_data
);
  localparam int BUS_W = SLOTS * 8;

  logic [7:0] hdr [HDR_BYTES];
  logic [7:0] pay [PAY_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_BYTES; i++) hdr[i] <= '0;
      for (int i = 0; i < PAY_BYTES; i++) pay[i] <= '0;
    end else begin
      for (int i = 0; i < HDR_BYTES; i++)
        if (wr_en && wr_idx == IW'(i)) hdr[i] <= wr_data;
      for (int i = 0; i < PAY_BYTES; i++) begin
        if (wr_en && wr_idx == IW'(HDR_BYTES + i)) pay[i] <= wr_data;
        else if (ld_en) pay[i] <= ld_data[BUS_W-1-8*i -: 8];
      end
    end
  end

  // pad slots have no storage: they read as zero whatever came back
  for (genvar k = 0; k < SLOTS; k++) begin : g_pack
    if (k < PAY_BYTES) begin : g_data
      assign blk_data[BUS_W-1-8*k -: 8] = pay[k];
    end else begin : g_pad
      assign blk_data[BUS_W-1-8*k -: 8] = 8'h00;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < HDR_BYTES; i++)
      if (rd_idx == IW'(i)) rd_byte = hdr[i];
    for (int i = 0; i < PAY_BYTES; i++)
      if (rd_idx == IW'(HDR_BYTES + i)) rd_byte = pay[i];
  end
endmodule

// File: rtl/eps_egress.sv
module eps_egress #(
  parameter int FRAME_BYTES = 68,
  parameter int IW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          out_ready,
  output logic [IW-1:0] idx,
  output logic          sof,
  output logic          eof,
  output logic          last_fire
);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BYTES - 1);

  logic fire;

  assign fire      = active && out_ready;
  assign sof       = (idx == '0);
  assign eof       = (idx == LAST);
  assign last_fire = fire && eof;

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (fire) idx <= eof ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/eth_payload_splitter.sv
module eth_payload_splitter #(
  parameter int HDR_BYTES = 22,
  parameter int PAY_BYTES = 46,
  parameter int BLK_BYTES = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [7:0]                             in_data,
  input  logic                                   in_sof,
  input  logic                                   in_eof,
  output logic                                   blk_valid,
  input  logic                                   blk_ready,
  output logic [((PAY_BYTES+BLK_BYTES-1)/BLK_BYTES)*BLK_BYTES*8-1:0] blk_data,
  input  logic                                   ret_valid,
  output logic                                   ret_ready,
  input  logic [((PAY_BYTES+BLK_BYTES-1)/BLK_BYTES)*BLK_BYTES*8-1:0] ret_data,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [7:0]                             out_data,
  output logic                                   out_sof,
  output logic                                   out_eof,
  output logic                                   err_short
);
  import eps_pkg::*;

  localparam int NBLK        = (PAY_BYTES + BLK_BYTES - 1) / BLK_BYTES;
  localparam int SLOTS       = NBLK * BLK_BYTES;
  localparam int BUS_W       = SLOTS * 8;
  localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES;
  localparam int IW          = $clog2(FRAME_BYTES + 1);

  eps_state_e    state_q;
  logic          wr_en, done, last_fire, ld_en;
  logic [IW-1:0] wr_idx, rd_idx;

  assign in_ready  = (state_q == ST_COLLECT);
  assign blk_valid = (state_q == ST_OFFER);
  assign ret_ready = (state_q == ST_AWAIT);
  assign out_valid = (state_q == ST_EMIT);
  assign ld_en     = ret_ready && ret_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_COLLECT;
    else begin
      unique case (state_q)
        ST_COLLECT: if (done)      state_q <= ST_OFFER;
        ST_OFFER:   if (blk_ready) state_q <= ST_AWAIT;
        ST_AWAIT:   if (ret_valid) state_q <= ST_EMIT;
        ST_EMIT:    if (last_fire) state_q <= ST_COLLECT;
        default:                   state_q <= ST_COLLECT;
      endcase
    end
  end

  eps_ingest #(.FRAME_BYTES(FRAME_BYTES), .IW(IW)) u_ingest (
    .clk, .rst_n,
    .en        (in_ready),
    .in_valid,
    .in_sof,
    .in_eof,
    .wr_en,
    .wr_idx,
    .done,
    .err_short
  );

  eps_store #(.HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES), .SLOTS(SLOTS), .IW(IW)) u_store (
    .clk, .rst_n,
    .wr_en,
    .wr_idx,
    .wr_data  (in_data),
    .ld_en,
    .ld_data  (ret_data),
    .rd_idx,
    .rd_byte  (out_data),
    .blk_data
  );

  eps_egress #(.FRAME_BYTES(FRAME_BYTES), .IW(IW)) u_egress (
    .clk, .rst_n,
    .active    (out_valid),
    .out_ready,
    .idx       (rd_idx),
    .sof       (out_sof),
    .eof       (out_eof),
    .last_fire
  );
endmodule

// File: rtl/eps_checker.sv
module eps_checker #(
  parameter int BUS_W = 384
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic [BUS_W-1:0] blk_data,
  input logic             ret_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic             err_short
);
  p_blk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data));

  p_in_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid || ret_ready || out_valid) |-> !in_ready);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

  p_err_no_blk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_short |-> !blk_valid && in_ready);

  p_ret_after_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_ready) |-> $past(blk_valid && blk_ready));

  p_emit_starts_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof && !out_eof);
endmodule

bind eth_payload_splitter eps_checker #(.BUS_W(BUS_W)) u_eps_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_data  (blk_data),
  .ret_ready (ret_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .err_short (err_short)
);

// File: tb/tb_eth_payload_splitter.sv
module tb_eth_payload_splitter;
  localparam int HB = 22;
  localparam int PB = 46;
  localparam int FB = 68;
  localparam int W  = 384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic blk_ready = 1'b0, ret_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] ret_data = '0;
  logic in_ready, blk_valid, ret_ready, out_valid, out_sof, out_eof, err_short;
  logic [W-1:0] blk_data;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  eth_payload_splitter dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sof, .in_eof,
    .blk_valid, .blk_ready, .blk_data, .ret_valid, .ret_ready, .ret_data,
    .out_valid, .out_ready, .out_data, .out_sof, .out_eof, .err_short
  );

  function automatic logic [7:0] fbyte(int s, int i);
    return 8'((s * 37 + i * 11 + 5) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] rbyte(int s, int k);
    return 8'((s * 53 + k * 29 + 17) ^ 8'h5a);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_frame(int len, int seed, bit sof, bit eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fbyte(seed, i);
      in_sof   = sof && (i == 0);
      in_eof   = eof && (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // called at the negedge right after the last input byte
  task automatic process_frame(int seed, int hold);
    logic [W-1:0] exp_blk, snap;
    logic [7:0] pv;
    logic ps, pe, stalled;
    int n, cyc;
    exp_blk = '0;
    for (int k = 0; k < PB; k++) exp_blk[W-1-8*k -: 8] = fbyte(seed, HB + k);
    chk(blk_valid === 1'b1, "R4", "blk_valid after frame", W'(blk_valid), W'(1));
    chk(in_ready === 1'b0, "R4", "in_ready while offering", W'(in_ready), W'(0));
    chk(blk_data === exp_blk, "R2", "payload packing", blk_data, exp_blk);
    chk(blk_data[15:0] === 16'h0, "R3", "pad bytes zero", W'(blk_data[15:0]), W'(0));
    snap = blk_data;
    repeat (hold) @(negedge clk);
    chk(blk_valid === 1'b1 && blk_data === snap, "R4", "blocks held", blk_data, snap);
    blk_ready = 1'b1;
    @(negedge clk);
    blk_ready = 1'b0;
    chk(ret_ready === 1'b1 && blk_valid === 1'b0, "R8", "ret_ready after handoff", W'(ret_ready), W'(1));
    ret_data = '0;
    for (int k = 0; k < PB; k++) ret_data[W-1-8*k -: 8] = rbyte(seed, k);
    ret_data[15:0] = 16'hbeef;
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    chk(out_valid === 1'b1 && in_ready === 1'b0, "R8", "capture starts output", W'(out_valid), W'(1));
    n = 0; cyc = 0; stalled = 1'b0; pv = '0; ps = 1'b0; pe = 1'b0;
    while (n < FB && cyc < 1000) begin
      if (stalled)
        chk(out_valid === 1'b1 && out_data === pv && out_sof === ps && out_eof === pe,
            "R10", "output held under stall", W'(out_data), W'(pv));
      out_ready = ((cyc * 3 + seed) % 4) != 0;
      if (out_ready && out_valid) begin
        chk(out_data === ((n < HB) ? fbyte(seed, n) : rbyte(seed, n - HB)), "R9",
            $sformatf("byte %0d", n), W'(out_data),
            W'((n < HB) ? fbyte(seed, n) : rbyte(seed, n - HB)));
        chk(out_sof === (n == 0) && out_eof === (n == FB - 1), "R9",
            $sformatf("markers at byte %0d", n), W'({out_sof, out_eof}), W'({n == 0, n == FB - 1}));
        n++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        pv = out_data; ps = out_sof; pe = out_eof;
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R11", "input reopened after last byte",
        W'({in_ready, out_valid}), W'(2'b10));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b1 && blk_valid === 1'b0 && ret_ready === 1'b0 &&
        out_valid === 1'b0 && err_short === 1'b0, "R1", "reset state",
        W'({in_ready, blk_valid, ret_ready, out_valid, err_short}), W'(5'b10000));

    // normal frames with different patterns and hold times
    for (int s = 1; s <= 4; s++) begin
      send_frame(FB, s, 1'b1, 1'b1);
      process_frame(s, s);
    end

    // R5 every short end position
    for (int len = 1; len < FB; len++) begin
      send_frame(len, 100 + len, 1'b1, 1'b1);
      chk(err_short === 1'b1 && blk_valid === 1'b0 && in_ready === 1'b1, "R5",
          $sformatf("short frame len %0d", len), W'({err_short, blk_valid, in_ready}), W'(3'b101));
      @(negedge clk);
      chk(err_short === 1'b0, "R5", "error pulse one cycle", W'(err_short), W'(0));
    end
    send_frame(FB, 9, 1'b1, 1'b1);
    process_frame(9, 2);

    // R6 stray bytes without start marker are ignored
    send_frame(10, 77, 1'b0, 1'b1);
    chk(err_short === 1'b0 && blk_valid === 1'b0 && in_ready === 1'b1, "R6",
        "stray bytes ignored", W'({err_short, blk_valid, in_ready}), W'(3'b001));
    send_frame(FB, 11, 1'b1, 1'b1);
    process_frame(11, 1);

    // R6 restart in mid-frame
    send_frame(30, 55, 1'b1, 1'b0);
    chk(blk_valid === 1'b0, "R6", "partial frame pending", W'(blk_valid), W'(0));
    send_frame(FB, 12, 1'b1, 1'b1);
    process_frame(12, 3);

    // R7 over-long frame
    send_frame(FB + 9, 13, 1'b1, 1'b1);
    process_frame(13, 2);

    // R3 pads again zero after nonzero returned pads, exactly at minimum length
    send_frame(FB, 14, 1'b1, 1'b1);
    process_frame(14, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule